// File: doc/BRIEF.md
# Board Interrupt Expander

This block collects up to sixteen board-level interrupt sources and presents them to a host as a single active-low, level-sensitive request line. Each source is watched for a rising edge. An edge sets a sticky status bit. A per-source mask decides whether a set status bit pulls the request line low. Software clears a status bit by holding a one in the matching bit of a write-only clear register. A later write of zero releases that clear.

The host reaches the block through a plain synchronous 16-bit register port. The port has an address, a write strobe with write data, and a read strobe with read data. Three read-only identification words with fixed values allow driver code to confirm that the board is fitted before it touches anything else. A read-only version word reports the firmware revision. Read data is combinational: it is valid in the same cycle as the read strobe and is zero whenever the strobe is low.

Top module: `irqx_top`

## Requirements
- R1: Reading byte offset 0x0 returns 0xAAAA, offset 0x2 returns 0x5555 and offset 0x4 returns 0xCAFE, at any time.
- R2: Reading offset 0x6 returns the parameter VERSION, which defaults to 0x0102.
- R3: A rising edge on source input i (0 then 1 on two consecutive clock edges) sets bit i of the status word at offset 0x8 at that second edge. A source held high does not set the bit again. A source that is high at the first edge after reset counts as a rising edge.
- R4: A status bit stays at 1 until it is cleared. Falling or steady source levels do not clear it.
- R5: The mask word at offset 0xA is written by a write strobe and reads back the written value. Bit i set to 1 disables source i, and bit i at 0 enables it.
- R6: irq_n is 0 exactly when some bit i has status 1 and mask 0. Otherwise irq_n is 1. If a masked source with its status bit set is unmasked, irq_n goes low with no new edge.
- R7: Writing the clear word at offset 0xC updates it at that clock edge. Every status bit whose clear bit is 1 reads 0 from the next edge on, and stays 0 while the clear bit is held, whatever its source does. Writing 0 releases the clear. Status bits whose clear bit is 0 are not affected.
- R8: When a clear bit is 1 at the same edge where its source rises, the clear wins and the status bit stays 0.
- R9: Reads of the clear word, of any unmapped offset (0xE and all odd offsets) and any read with rd_en low return 0.
- R10: After reset the status word is 0, the clear word is 0, the mask word is 0xFFFF and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NSRC | Board interrupt sources, rising edge sets status |
| addr | input | AW | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Read data, combinational, 0 when rd_en is low |
| irq_n | output | 1 | Combined interrupt request, active low, level |

## Verification
Two functions can act on the same status bit at one clock edge: a new source edge and an active clear. The bench provokes this in two ways. In the first, a source rises while its clear bit is held. In the second, a source rises in the very cycle when a write of zero to the clear register is captured, so the old clear value still governs that edge. A bench model states the clear-over-event priority directly, and the bench compares both the status read and irq_n against that model. The random phase mixes source toggling with mask and clear writes, so these collisions also occur without being planned.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int unsigned REG_W = 16;

  localparam logic [REG_W-1:0] ID_WORD0 = 16'hAAAA;
  localparam logic [REG_W-1:0] ID_WORD1 = 16'h5555;
  localparam logic [REG_W-1:0] ID_WORD2 = 16'hCAFE;

  localparam int unsigned OFS_ID0  = 'h0;
  localparam int unsigned OFS_ID1  = 'h2;
  localparam int unsigned OFS_ID2  = 'h4;
  localparam int unsigned OFS_VER  = 'h6;
  localparam int unsigned OFS_STAT = 'h8;
  localparam int unsigned OFS_MASK = 'hA;
  localparam int unsigned OFS_CLR  = 'hC;

  // one status bit: clear dominates, otherwise sticky OR event
  function automatic logic stat_bit_next(logic cur, logic evt, logic clr);
    return clr ? 1'b0 : (cur | evt);
  endfunction

  function automatic logic rise_of(logic now_v, logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic [REG_W-1:0] pend_vec(logic [REG_W-1:0] stat,
                                                logic [REG_W-1:0] mask);
    return stat & ~mask;
  endfunction
endpackage

// File: rtl/irqx_edge_status.sv
module irqx_edge_status
  import irqx_pkg::*;
#(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] rise_evt,
  output logic [NSRC-1:0] stat_q
);
  logic [NSRC-1:0] prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    assign rise_evt[i] = rise_of(src_in[i], prev_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        stat_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= src_in[i];
        stat_q[i] <= stat_bit_next(stat_q[i], rise_evt[i], clr_bits[i]);
      end
    end

    AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_bits[i] |=> !stat_q[i]); // R7
    AST_CLR_BEATS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits[i] && rise_evt[i]) |=> !stat_q[i]); // R8
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_evt[i] && !clr_bits[i]) |=> stat_q[i]); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_bits[i]) |=> stat_q[i]); // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[i] && !rise_evt[i]) |=> !stat_q[i]); // R3
  end
endmodule

// File: rtl/irqx_ctrl_regs.sv
module irqx_ctrl_regs
  import irqx_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] clr_q
);
  logic hit_mask;
  logic hit_clr;

  assign hit_mask = wr_en && (addr == AW'(OFS_MASK));
  assign hit_clr  = wr_en && (addr == AW'(OFS_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      clr_q  <= '0;
    end else begin
      if (hit_mask) mask_q <= wr_data;
      if (hit_clr)  clr_q  <= wr_data;
    end
  end

  AST_CLR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_clr |=> $stable(clr_q)); // R7
endmodule

// File: rtl/irqx_read_mux.sv
module irqx_read_mux
  import irqx_pkg::*;
#(
  parameter int unsigned  AW      = 4,
  parameter int unsigned  DW      = 16,
  parameter int unsigned  NSRC    = 16,
  parameter logic [DW-1:0] VERSION = 16'h0102
) (
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] stat,
  input  logic [DW-1:0]   mask,
  output logic [DW-1:0]   rd_data
);
  logic [DW-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    if      (addr == AW'(OFS_ID0))  sel_word = DW'(ID_WORD0);
    else if (addr == AW'(OFS_ID1))  sel_word = DW'(ID_WORD1);
    else if (addr == AW'(OFS_ID2))  sel_word = DW'(ID_WORD2);
    else if (addr == AW'(OFS_VER))  sel_word = VERSION;
    else if (addr == AW'(OFS_STAT)) sel_word = DW'(stat);
    else if (addr == AW'(OFS_MASK)) sel_word = mask;
    // clear word is write-only, others unmapped: zero
  end

  assign rd_data = rd_en ? sel_word : '0;

  always_comb begin
    if (!rd_en) AST_IDLE_ZERO: assert (rd_data == '0); // R9
  end
endmodule

// File: rtl/irqx_top.sv
module irqx_top
  import irqx_pkg::*;
#(
  parameter int unsigned   NSRC    = 16,
  parameter int unsigned   AW      = 4,
  parameter int unsigned   DW      = REG_W,
  parameter logic [DW-1:0] VERSION = 16'h0102
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  output logic            irq_n
);
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] rise_evt;
  logic [DW-1:0]   mask_q;
  logic [DW-1:0]   clr_q;
  logic [REG_W-1:0] pending;

  irqx_ctrl_regs #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .mask_q(mask_q), .clr_q(clr_q)
  );

  irqx_edge_status #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .clr_bits(clr_q[NSRC-1:0]), .rise_evt(rise_evt), .stat_q(stat_q)
  );

  irqx_read_mux #(.AW(AW), .DW(DW), .NSRC(NSRC), .VERSION(VERSION)) u_rd (
    .rd_en(rd_en), .addr(addr), .stat(stat_q), .mask(mask_q),
    .rd_data(rd_data)
  );

  assign pending = pend_vec(REG_W'(stat_q), REG_W'(mask_q[NSRC-1:0]));
  assign irq_n   = ~|pending;

  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && addr == AW'(OFS_MASK)) && !wr_en && rd_en && addr == AW'(OFS_MASK))
      |-> rd_data == $past(wr_data)); // R5
  AST_QUIET_WHEN_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[NSRC-1:0]) |-> irq_n); // R6
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (&clr_q[NSRC-1:0]) |=> irq_n); // R7
endmodule

// File: tb/tb_irqx_top.sv
`timescale 1ns/1ps
module tb_irqx_top;
  localparam int NSRC = 16;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [15:0] VER = 16'h0102;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic irq_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_stat, m_mask, m_clr, m_prev;

  irqx_top #(.NSRC(NSRC), .AW(AW), .DW(DW), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic exp_irq_n(logic [15:0] s, logic [15:0] m);
    for (int b = 0; b < 16; b++) if (s[b] && !m[b]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string req, input logic [15:0] exp);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    chk(req, rd_data, exp);
    rd_en = 1'b0;
    #1;
  endtask

  // one clock with inputs applied at negedge; model updated per requirements
  task automatic step(input logic [15:0] src, input logic we,
                      input logic [3:0] a, input logic [15:0] wd);
    logic [15:0] evt;
    src_in = src; wr_en = we; addr = a; wr_data = wd; rd_en = 1'b0;
    @(posedge clk);
    evt = src & ~m_prev;
    m_stat = (m_stat | evt) & ~m_clr;   // R8: clear wins
    m_prev = src;
    if (we && a == 4'hA) m_mask = wd;
    if (we && a == 4'hC) m_clr = wd;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R6 irq_n"}, {15'd0, irq_n}, {15'd0, exp_irq_n(m_stat, m_mask)});
    rd(4'h8, {tag, " R4 status"}, m_stat);
  endtask

  initial begin
    while (!done && cyc < 200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    m_stat = '0; m_mask = '1; m_clr = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq_n reset", {15'd0, irq_n}, 16'h0001);
    rd(4'h8, "R10 status reset", 16'h0000);
    rd(4'hA, "R10 mask reset", 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2 / R9
    rd(4'h0, "R1 id0", 16'hAAAA);
    rd(4'h2, "R1 id1", 16'h5555);
    rd(4'h4, "R1 id2", 16'hCAFE);
    rd(4'h6, "R2 version", VER);
    rd(4'hC, "R9 clear write-only", 16'h0000);
    rd(4'hE, "R9 unmapped 0xE", 16'h0000);
    rd(4'h3, "R9 odd offset", 16'h0000);
    addr = 4'h0; rd_en = 1'b0; #1;
    chk("R9 rd_en low", rd_data, 16'h0000);

    // R3 masked edge: status set, irq stays high
    step(16'h0008, 0, 0, 0);
    check_state("R3 masked edge");
    rd(4'h8, "R3 bit3 set", 16'h0008);
    // R5 write mask, readback; R6 unmask pending -> irq low
    step(16'h0008, 1, 4'hA, 16'hFFF7);
    rd(4'hA, "R5 mask readback", 16'hFFF7);
    chk("R6 unmask pending", {15'd0, irq_n}, 16'h0000);
    // R4 source falls, status stays
    step(16'h0000, 0, 0, 0);
    rd(4'h8, "R4 sticky after fall", 16'h0008);
    // R3 held level no retrigger: set source bit 5 high, hold
    step(16'h0020, 0, 0, 0);
    step(16'h0020, 0, 0, 0);
    rd(4'h8, "R3 bit5 set", 16'h0028);
    // R7 clear bit3 only
    step(16'h0020, 1, 4'hC, 16'h0008);
    step(16'h0020, 0, 0, 0);
    rd(4'h8, "R7 bit3 cleared bit5 kept", 16'h0020);
    chk("R7 irq_n after clear", {15'd0, irq_n}, 16'h0001);
    // R8 edge on bit3 while clear held
    step(16'h0028, 0, 0, 0);
    rd(4'h8, "R8 held clear beats edge", 16'h0020);
    // release with simultaneous edge on bit3 (drop first)
    step(16'h0020, 0, 0, 0);
    step(16'h0028, 1, 4'hC, 16'h0000);
    rd(4'h8, "R8 edge at release edge lost", 16'h0020);
    step(16'h0020, 0, 0, 0);
    step(16'h0028, 0, 0, 0);
    rd(4'h8, "R7 released, edge sets", 16'h0028);
    // full clear
    step(16'h0000, 1, 4'hC, 16'hFFFF);
    step(16'h0000, 1, 4'hC, 16'h0000);
    rd(4'h8, "R7 clear all", 16'h0000);
    check_state("R7 after clear all");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 9);
      s = src_in ^ 16'($urandom) & 16'($urandom);
      if (k == 0)      step(s, 1, 4'hA, 16'($urandom));
      else if (k == 1) step(s, 1, 4'hC, 16'($urandom) & 16'($urandom));
      else if (k == 2) step(s, 1, 4'hC, 16'h0000);
      else             step(s, 0, 4'h0, 16'h0000);
      check_state("rand");
      if (n % 50 == 0) begin
        rd(4'hA, "R5 rand mask", m_mask);
        rd(4'h4, "R1 rand id2", 16'hCAFE);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule